// File: doc/BRIEF.md
# LCD Frame Interrupt and Pixel Write Gate

This block sits next to a multiplexed LCD timing generator and decides two things: when software is told something happened, and when software is allowed to change pixel data. It raises a single sticky interrupt flag when the display controller finishes shutting down, and when the controller has finished reading a frame's pixel data in a mode where the next update has to be timed. The block raises no interrupt in the other modes.

With the balanced two-frame drive scheme and a multiplexed common count, each pixel's drive in the second frame of a pair must be the exact inverse of the first, so the pixel data may only change between pairs. The block tracks the frame phase, raises the frame interrupt only at the end of each pair, and opens a write window of fixed length from that point. Pixel writes inside the window are passed on one cycle later. Writes outside it are dropped and set a sticky write-error flag. In every other mode the window stays open.

Top module: `lcd_frame_irq`

## Requirements
- R1: When `ctl_active` is high in one cycle and low in the next, `irq_flag` is 1 after the clock edge that samples the low value.
- R2: Gated mode means `wave_b`=1 and `mux_sel`≠0. In this mode a phase bit starts at 0 and toggles on every `frame_start`. A frame event happens when `access_done` is sampled while `ctl_active`=1 and the phase bit is 0, so an event falls only on the second frame of each pair after enabling. A frame event sets `irq_flag`.
- R3: With `wave_b`=0, or with `mux_sel`=0, `access_done` never sets `irq_flag`.
- R4: In gated mode, `wr_window` is 1 for exactly WIN_CYCLES cycles, starting with the cycle after the edge that samples a frame event. Otherwise it is 0.
- R5: Outside gated mode, `wr_window` is 1 in every cycle.
- R6: A `wr_req` sampled while `wr_window`=1 gives `pix_we`=1 after that edge, with `pix_addr`/`pix_data` carrying the request's address and data.
- R7: A `wr_req` sampled while `wr_window`=0 sets `werr_flag` and leaves `pix_we`=0 and `pix_addr`/`pix_data` unchanged.
- R8: `irq_flag` and `werr_flag` stay set until their clear input (`irq_clr`, `werr_clr`) is sampled. A set event in the same cycle as a clear leaves the flag set.
- R9: A rising edge of `ctl_active` returns the phase bit to 0 and closes the window. This restart takes priority over a frame start or a frame event in the same cycle.
- R10: After reset both flags and `pix_we` are 0, the phase bit is 0 and the window counter is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_active | input | 1 | Display controller active status |
| wave_b | input | 1 | Waveform type: 1 = balanced two-frame (B), 0 = single-frame (A) |
| mux_sel | input | 2 | Common multiplex select, 0 = static drive |
| frame_start | input | 1 | One-cycle strobe at the leading edge of common line 0 |
| access_done | input | 1 | One-cycle strobe when a frame's pixel data has been read |
| wr_req | input | 1 | Pixel write request |
| wr_addr | input | AW | Pixel write address |
| wr_data | input | DW | Pixel write data |
| irq_clr | input | 1 | Clears `irq_flag` |
| werr_clr | input | 1 | Clears `werr_flag` |
| irq_flag | output | 1 | Sticky interrupt flag |
| wr_window | output | 1 | Pixel writes currently allowed |
| werr_flag | output | 1 | Sticky write-error flag |
| pix_we | output | 1 | Gated pixel write strobe |
| pix_addr | output | AW | Address of the gated write |
| pix_data | output | DW | Data of the gated write |

## Verification
The assertions assume that the strobes and requests are sampled synchronously and that the mode inputs hold steady around a clock edge. They do not assume that `access_done` follows a `frame_start` or that the mode stays fixed across a frame pair. The random stimulus therefore drives every input at the falling edge and changes the waveform type, multiplex select and active status at arbitrary points, often mid-pair. Directed sequences place writes on the first and last window cycles, on the cycle just after the window, and alongside clears.

// File: rtl/lcdfi_pkg.sv
package lcdfi_pkg;

  typedef enum logic {
    WAVE_A = 1'b0,
    WAVE_B = 1'b1
  } wave_e;

  localparam int FLAG_IRQ  = 0;
  localparam int FLAG_WERR = 1;
  localparam int NUM_FLAGS = 2;

  // Writes are windowed only for balanced drive with a multiplexed common count
  function automatic logic writes_gated(input wave_e wave, input logic [1:0] mux);
    return (wave == WAVE_B) && (mux != 2'b00);
  endfunction

  // Next value of the window down-counter; restart beats load beats decrement
  function automatic int unsigned win_step(input int unsigned cnt, input logic load,
                                           input logic restart, input int unsigned len);
    if (restart)      return 0;
    else if (load)    return len;
    else if (cnt > 0) return cnt - 1;
    else              return 0;
  endfunction

endpackage

// File: rtl/lcdfi_activity.sv
module lcdfi_activity (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic shut_evt_o,
  output logic wake_evt_o
);

  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= active_i;
  end

  assign shut_evt_o = act_q & ~active_i;
  assign wake_evt_o = ~act_q & active_i;

endmodule

// File: rtl/lcdfi_phase.sv
module lcdfi_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic gated_i,
  input  logic active_i,
  input  logic frame_start_i,
  input  logic access_done_i,
  output logic frame_evt_o
);

  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase_q <= 1'b0;
    else if (restart_i)     phase_q <= 1'b0;
    else if (frame_start_i) phase_q <= ~phase_q;
  end

  // Second frame of a pair has phase 0 (toggled twice since enable)
  assign frame_evt_o = gated_i & active_i & access_done_i & ~phase_q;

  assert_restart_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !phase_q);

  assert_toggle_on_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && !restart_i) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/lcdfi_window.sv
module lcdfi_window #(
  parameter int unsigned WIN_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic load_i,
  input  logic gated_i,
  output logic open_o
);
  import lcdfi_pkg::*;

  localparam int CW = $clog2(WIN_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign cnt_d = CW'(win_step(int'(cnt_q), load_i, restart_i, WIN_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign open_o = ~gated_i | (cnt_q != '0);

  assert_open_after_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !restart_i) |=> open_o);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= int'(WIN_CYCLES));

endmodule

// File: rtl/lcdfi_flags.sv
module lcdfi_flags #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_set_i,
  input  logic          irq_clr_i,
  input  logic          werr_clr_i,
  input  logic          wr_req_i,
  input  logic          wr_open_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          irq_flag_o,
  output logic          werr_flag_o,
  output logic          pix_we_o,
  output logic [AW-1:0] pix_addr_o,
  output logic [DW-1:0] pix_data_o
);
  import lcdfi_pkg::*;

  logic [NUM_FLAGS-1:0] set_v;
  logic [NUM_FLAGS-1:0] clr_v;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 accept;

  assign accept          = wr_req_i & wr_open_i;
  assign set_v[FLAG_IRQ]  = irq_set_i;
  assign set_v[FLAG_WERR] = wr_req_i & ~wr_open_i;
  assign clr_v[FLAG_IRQ]  = irq_clr_i;
  assign clr_v[FLAG_WERR] = werr_clr_i;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_v[i]) flag_q[i] <= 1'b1;
      else if (clr_v[i]) flag_q[i] <= 1'b0;
    end

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[i] && !set_v[i]) |=> !flag_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_we_o   <= 1'b0;
      pix_addr_o <= '0;
      pix_data_o <= '0;
    end else begin
      pix_we_o <= accept;
      if (accept) begin
        pix_addr_o <= wr_addr_i;
        pix_data_o <= wr_data_i;
      end
    end
  end

  assign irq_flag_o  = flag_q[FLAG_IRQ];
  assign werr_flag_o = flag_q[FLAG_WERR];

  assert_irq_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_i |=> irq_flag_o);

  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && !wr_open_i) |=> (werr_flag_o && !pix_we_o && $stable(pix_addr_o)));

  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_i && wr_open_i) |=> (pix_we_o && pix_data_o == $past(wr_data_i)));

endmodule

// File: rtl/lcd_frame_irq.sv
module lcd_frame_irq #(
  parameter int unsigned WIN_CYCLES = 6,
  parameter int          AW         = 5,
  parameter int          DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_active,
  input  logic          wave_b,
  input  logic [1:0]    mux_sel,
  input  logic          frame_start,
  input  logic          access_done,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_clr,
  input  logic          werr_clr,
  output logic          irq_flag,
  output logic          wr_window,
  output logic          werr_flag,
  output logic          pix_we,
  output logic [AW-1:0] pix_addr,
  output logic [DW-1:0] pix_data
);
  import lcdfi_pkg::*;

  logic shut_evt;
  logic wake_evt;
  logic frame_evt;
  logic gated;

  assign gated = writes_gated(wave_e'(wave_b), mux_sel);

  lcdfi_activity u_activity (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (ctl_active),
    .shut_evt_o (shut_evt),
    .wake_evt_o (wake_evt)
  );

  lcdfi_phase u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart_i     (wake_evt),
    .gated_i       (gated),
    .active_i      (ctl_active),
    .frame_start_i (frame_start),
    .access_done_i (access_done),
    .frame_evt_o   (frame_evt)
  );

  lcdfi_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (wake_evt),
    .load_i    (frame_evt),
    .gated_i   (gated),
    .open_o    (wr_window)
  );

  lcdfi_flags #(.AW(AW), .DW(DW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_set_i   (shut_evt | frame_evt),
    .irq_clr_i   (irq_clr),
    .werr_clr_i  (werr_clr),
    .wr_req_i    (wr_req),
    .wr_open_i   (wr_window),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .irq_flag_o  (irq_flag),
    .werr_flag_o (werr_flag),
    .pix_we_o    (pix_we),
    .pix_addr_o  (pix_addr),
    .pix_data_o  (pix_data)
  );

  assert_window_open_ungated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wave_b || mux_sel == 2'b00) |-> wr_window);

  assert_no_frame_irq_ungated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wave_b && !ctl_active && !irq_flag && !irq_clr && $past(!ctl_active)) |=> !irq_flag);

endmodule

// File: tb/tb_lcd_frame_irq.sv
module tb_lcd_frame_irq;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 6;
  localparam int AW = 5;
  localparam int DW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic ctl_active = 0, wave_b = 0, frame_start = 0, access_done = 0;
  logic wr_req = 0, irq_clr = 0, werr_clr = 0;
  logic [1:0] mux_sel = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic irq_flag, wr_window, werr_flag, pix_we;
  logic [AW-1:0] pix_addr;
  logic [DW-1:0] pix_data;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_prev = 0, m_phase = 0, m_irq = 0, m_werr = 0, m_we = 0;
  int m_cnt = 0;
  bit [AW-1:0] m_addr = 0;
  bit [DW-1:0] m_data = 0;

  lcd_frame_irq #(.WIN_CYCLES(W), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_active(ctl_active), .wave_b(wave_b),
    .mux_sel(mux_sel), .frame_start(frame_start), .access_done(access_done),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_clr(irq_clr), .werr_clr(werr_clr), .irq_flag(irq_flag),
    .wr_window(wr_window), .werr_flag(werr_flag), .pix_we(pix_we),
    .pix_addr(pix_addr), .pix_data(pix_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_gated(bit w, bit [1:0] m);
    return (m != 2'b00) & w;
  endfunction

  function automatic bit exp_window(bit w, bit [1:0] m, int cnt);
    if (!exp_gated(w, m)) return 1'b1;
    return cnt > 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input bit a, input bit w, input bit [1:0] m, input bit fs,
                     input bit dn, input bit wr, input bit ic, input bit wc);
    bit fall, rise, fevt, win;
    @(negedge clk);
    ctl_active = a; wave_b = w; mux_sel = m; frame_start = fs; access_done = dn;
    wr_req = wr; irq_clr = ic; werr_clr = wc;
    wr_addr = AW'($urandom); wr_data = DW'($urandom);
    fall = m_prev && !a;
    rise = !m_prev && a;
    fevt = exp_gated(w, m) && a && dn && (m_phase == 1'b0);
    win  = exp_window(w, m, m_cnt);
    if (fall || fevt) m_irq = 1; else if (ic) m_irq = 0;
    if (wr && !win) m_werr = 1; else if (wc) m_werr = 0;
    m_we = wr && win;
    if (m_we) begin m_addr = wr_addr; m_data = wr_data; end
    if (rise) m_cnt = 0; else if (fevt) m_cnt = W; else if (m_cnt > 0) m_cnt = m_cnt - 1;
    if (rise) m_phase = 0; else if (fs) m_phase = ~m_phase;
    m_prev = a;
    @(posedge clk);
    #1;
    chk("irq_flag (R1 R2 R3 R8)", 32'(irq_flag), 32'(m_irq));
    chk("werr_flag (R7 R8)", 32'(werr_flag), 32'(m_werr));
    chk("pix_we (R6 R7)", 32'(pix_we), 32'(m_we));
    chk("wr_window (R4 R5 R9)", 32'(wr_window), 32'(exp_window(w, m, m_cnt)));
    chk("pix_addr (R6 R7)", 32'(pix_addr), 32'(m_addr));
    chk("pix_data (R6 R7)", 32'(pix_data), 32'(m_data));
  endtask

  task automatic idle(input bit a, input bit w, input bit [1:0] m, input int n);
    for (int i = 0; i < n; i++) cyc(a, w, m, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (R10): got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1CD0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state (ungated inputs so window reads open)
    chk("reset irq_flag (R10)", 32'(irq_flag), 0);
    chk("reset werr_flag (R10)", 32'(werr_flag), 0);
    chk("reset pix_we (R10)", 32'(pix_we), 0);
    chk("reset wr_window (R10 R5)", 32'(wr_window), 1);

    // Gated: enable, window closed, write rejected (R7, R9)
    cyc(1, 1, 2'd3, 0, 0, 1, 0, 0);
    cyc(1, 1, 2'd3, 0, 0, 0, 0, 1);
    // first frame: access done must not interrupt (R2)
    cyc(1, 1, 2'd3, 1, 0, 0, 0, 0);
    idle(1, 1, 2'd3, 3);
    cyc(1, 1, 2'd3, 0, 1, 0, 0, 0);
    idle(1, 1, 2'd3, 2);
    // second frame: event, window opens for W cycles (R2 R4)
    cyc(1, 1, 2'd3, 1, 0, 0, 0, 0);
    idle(1, 1, 2'd3, 3);
    cyc(1, 1, 2'd3, 0, 1, 0, 0, 0);
    cyc(1, 1, 2'd3, 0, 0, 1, 0, 0);           // first window cycle (R6)
    idle(1, 1, 2'd3, W - 2);
    cyc(1, 1, 2'd3, 0, 0, 1, 1, 0);           // last window cycle, clear irq (R6 R8)
    cyc(1, 1, 2'd3, 0, 0, 1, 0, 0);           // just after window (R7)
    // set and clear together: set wins (R8)
    cyc(1, 1, 2'd3, 0, 0, 1, 0, 1);
    cyc(1, 1, 2'd3, 0, 0, 0, 0, 1);
    // shutdown interrupt (R1)
    cyc(0, 1, 2'd3, 0, 0, 0, 0, 0);
    cyc(0, 1, 2'd3, 0, 0, 0, 1, 0);
    // Type A: no frame interrupt, writes always allowed (R3 R5)
    cyc(1, 0, 2'd2, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      cyc(1, 0, 2'd2, 1, 0, 1, 0, 0);
      cyc(1, 0, 2'd2, 0, 1, 1, 0, 0);
    end
    // static Type B: no frame interrupt (R3 R5)
    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 2'd0, 1, 0, 1, 0, 0);
      cyc(1, 1, 2'd0, 0, 1, 1, 0, 0);
    end
    // re-enable mid-window restarts phase and closes window (R9)
    cyc(0, 1, 2'd1, 0, 0, 0, 1, 1);
    cyc(1, 1, 2'd1, 1, 1, 1, 1, 1);
    cyc(1, 1, 2'd1, 0, 1, 1, 0, 0);

    // constrained random
    begin
      bit a = 1, w = 1;
      bit [1:0] m = 2'd2;
      for (int n = 0; n < 6000; n++) begin
        if ($urandom_range(0, 99) < 2) a = ~a;
        if ($urandom_range(0, 99) < 1) w = ~w;
        if ($urandom_range(0, 99) < 1) m = 2'($urandom);
        cyc(a, w, m, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
            $urandom_range(0, 9) < 3, $urandom_range(0, 15) == 0,
            $urandom_range(0, 15) == 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule